// File: doc/BRIEF.md
# TLB-Invalidate System Instruction Trap Gate

This block sits beside the system-instruction decode path of a processor core and decides, for a coprocessor-style system instruction, what should happen when the core presents it. It targets one instruction, the invalidate-by-address, last-level, inner-shareable TLB maintenance operation. It compares the five encoding fields against that instruction's encoding. It then looks at the current exception level, whether the hypervisor level is enabled, and whether the hypervisor runs in 64-bit or 32-bit state. From these it picks one of five outcomes: not this instruction, undefined, trap to a 64-bit hypervisor, trap to a 32-bit hypervisor, or execute.

Each execution state of the hypervisor has its own bank of trap controls. A bank holds a 16-bit mask with one bit per primary register number, a TLB-maintenance trap bit and an inner-shareable TLB trap bit. Only the bank of the current hypervisor state is consulted. Within that bank, the bits are checked in a fixed order and the winning cause is reported. Any trap carries exception class 0x03. The result is registered and appears one cycle after the input strobe. Carrying out the invalidate is left to the consumer.

Top module: `sysop_trap_gate`

## Requirements
- R1: While `rst` is high at a clock edge, and after it, until a strobe is taken, `res_valid`, `res_outcome`, `res_class` and `res_cause` are all zero.
- R2: `res_valid` is high in the cycle after a cycle with `req_valid` high, and low in the cycle after a cycle with `req_valid` low.
- R3: When `res_valid` is high, exactly one bit of `res_outcome` is set. When it is low, `res_outcome` is zero. The bit positions are: bit0 not this instruction, bit1 undefined, bit2 trap to 64-bit hypervisor, bit3 trap to 32-bit hypervisor, bit4 execute.
- R4: If any field differs from coproc=0b1111, opc1=0b000, CRn=0b1000, CRm=0b0011, opc2=0b101, the outcome is bit0, with class 0 and cause 0, whatever the level and trap controls.
- R5: A matching instruction at level 0 (`cur_el`=0) gives outcome bit1.
- R6: A matching instruction at level 2 or 3 gives outcome bit4, whatever the trap controls.
- R7: A matching instruction at level 1 with `el2_on` low gives outcome bit4, whatever the trap controls.
- R8: At level 1 with `el2_on` high and `el2_aa32` low, only the 64-bit bank is consulted. If its mask bit at index CRn is set, or its TLB or inner-shareable bit is set, the outcome is bit2. Otherwise it is bit4.
- R9: At level 1 with `el2_on` high and `el2_aa32` high, only the 32-bit bank is consulted, with the same three conditions. A trap gives outcome bit3, otherwise bit4.
- R10: `res_cause` names the highest-priority set condition of the consulted bank: 1 for the mask bit, else 2 for the TLB bit, else 3 for the inner-shareable bit. It is 0 when no trap is taken.
- R11: `res_class` is 0x03 with any trap outcome and 0 with every other outcome.
- R12: Only the mask bit whose index equals the CRn field (bit 8) can cause a trap. The other 15 mask bits have no effect on the outcome.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Instruction presented this cycle |
| enc_cp | input | 4 | Coprocessor number field |
| enc_op1 | input | 3 | First opcode field |
| enc_crn | input | 4 | Primary register number field |
| enc_crm | input | 4 | Secondary register number field |
| enc_op2 | input | 3 | Second opcode field |
| cur_el | input | 2 | Current exception level, 0 to 3 |
| el2_on | input | 1 | Hypervisor level implemented and enabled |
| el2_aa32 | input | 1 | Hypervisor level runs in 32-bit state |
| a64_crn_mask | input | 16 | 64-bit bank: trap bit per primary register number |
| a64_tlb_trap | input | 1 | 64-bit bank: TLB-maintenance trap |
| a64_tlbis_trap | input | 1 | 64-bit bank: inner-shareable TLB trap |
| a32_crn_mask | input | 16 | 32-bit bank: trap bit per primary register number |
| a32_tlb_trap | input | 1 | 32-bit bank: TLB-maintenance trap |
| a32_tlbis_trap | input | 1 | 32-bit bank: inner-shareable TLB trap |
| res_valid | output | 1 | Result valid, one cycle after `req_valid` |
| res_outcome | output | 5 | One-hot outcome |
| res_class | output | 6 | Exception class, 0x03 on a trap |
| res_cause | output | 2 | Winning trap condition |

## Verification
The hardest case to reach from the ports is a priority decision inside one bank while the other bank is fully armed. The cause output must come from the bank selected by the hypervisor state, and a stray mask bit must have no effect. The stimulus table therefore sets several conditions at once. It arms every control of the unused bank, sets both TLB bits together, and sets every mask bit except the one selected by CRn. Each of these vectors isolates one ordering or selection decision. The directed tests then cover back-to-back strobes and a reset that arrives while a result is pending.

// File: rtl/sysop_trap_pkg.sv
package sysop_trap_pkg;

    localparam int OUT_W   = 5;
    localparam int CAUSE_W = 2;

    typedef enum logic [1:0] {
        LVL_0 = 2'd0,
        LVL_1 = 2'd1,
        LVL_2 = 2'd2,
        LVL_3 = 2'd3
    } level_e;

    typedef enum logic [OUT_W-1:0] {
        OC_NONE    = 5'b00000,
        OC_NOMATCH = 5'b00001,
        OC_UNDEF   = 5'b00010,
        OC_TRAP64  = 5'b00100,
        OC_TRAP32  = 5'b01000,
        OC_EXEC    = 5'b10000
    } outcome_e;

    typedef enum logic [CAUSE_W-1:0] {
        CS_NONE  = 2'd0,
        CS_CRN   = 2'd1,
        CS_TLB   = 2'd2,
        CS_TLBIS = 2'd3
    } cause_e;

    typedef struct packed {
        logic crn_hit;
        logic tlb;
        logic tlbis;
    } trap_ctl_t;

    typedef struct packed {
        outcome_e outcome;
        cause_e   cause;
        logic     trap;
    } verdict_t;

    function automatic logic is_trap(outcome_e oc);
        return (oc == OC_TRAP64) || (oc == OC_TRAP32);
    endfunction

endpackage

// File: rtl/sysop_enc_match.sv
module sysop_enc_match #(
    parameter int CP_W   = 4,
    parameter int OP1_W  = 3,
    parameter int CRN_W  = 4,
    parameter int CRM_W  = 4,
    parameter int OP2_W  = 3,
    parameter logic [CP_W-1:0]  M_CP  = 4'b1111,
    parameter logic [OP1_W-1:0] M_OP1 = 3'b000,
    parameter logic [CRN_W-1:0] M_CRN = 4'b1000,
    parameter logic [CRM_W-1:0] M_CRM = 4'b0011,
    parameter logic [OP2_W-1:0] M_OP2 = 3'b101
) (
    input  logic [CP_W-1:0]  cp,
    input  logic [OP1_W-1:0] op1,
    input  logic [CRN_W-1:0] crn,
    input  logic [CRM_W-1:0] crm,
    input  logic [OP2_W-1:0] op2,
    output logic             hit
);
    localparam int NFIELD = 5;

    logic [NFIELD-1:0] field_eq;

    always_comb begin
        field_eq[0] = (cp  == M_CP);
        field_eq[1] = (op1 == M_OP1);
        field_eq[2] = (crn == M_CRN);
        field_eq[3] = (crm == M_CRM);
        field_eq[4] = (op2 == M_OP2);
    end

    assign hit = &field_eq;
endmodule

// File: rtl/sysop_trap_prio.sv
module sysop_trap_prio
    import sysop_trap_pkg::*;
(
    input  trap_ctl_t ctl,
    output logic      trap,
    output cause_e    cause
);
    always_comb begin
        if (ctl.crn_hit) begin
            cause = CS_CRN;
        end else if (ctl.tlb) begin
            cause = CS_TLB;
        end else if (ctl.tlbis) begin
            cause = CS_TLBIS;
        end else begin
            cause = CS_NONE;
        end
        trap = (cause != CS_NONE);
    end
endmodule

// File: rtl/sysop_result_reg.sv
module sysop_result_reg
    import sysop_trap_pkg::*;
#(
    parameter int               EC_W    = 6,
    parameter logic [EC_W-1:0]  TRAP_EC = 6'h03
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            take,
    input  verdict_t        vin,
    output logic            q_valid,
    output outcome_e        q_outcome,
    output logic [EC_W-1:0] q_class,
    output cause_e          q_cause
);
    always_ff @(posedge clk) begin
        if (rst || !take) begin
            q_valid   <= 1'b0;
            q_outcome <= OC_NONE;
            q_class   <= '0;
            q_cause   <= CS_NONE;
        end else begin
            q_valid   <= 1'b1;
            q_outcome <= vin.outcome;
            q_class   <= vin.trap ? TRAP_EC : '0;
            q_cause   <= vin.cause;
        end
    end
endmodule

// File: rtl/sysop_trap_gate.sv
module sysop_trap_gate
    import sysop_trap_pkg::*;
#(
    parameter int CP_W  = 4,
    parameter int OP1_W = 3,
    parameter int CRN_W = 4,
    parameter int CRM_W = 4,
    parameter int OP2_W = 3,
    parameter int EC_W  = 6,
    parameter logic [EC_W-1:0] TRAP_EC = 6'h03,
    localparam int MASK_W = 1 << CRN_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [CP_W-1:0]    enc_cp,
    input  logic [OP1_W-1:0]   enc_op1,
    input  logic [CRN_W-1:0]   enc_crn,
    input  logic [CRM_W-1:0]   enc_crm,
    input  logic [OP2_W-1:0]   enc_op2,
    input  logic [1:0]         cur_el,
    input  logic               el2_on,
    input  logic               el2_aa32,
    input  logic [MASK_W-1:0]  a64_crn_mask,
    input  logic               a64_tlb_trap,
    input  logic               a64_tlbis_trap,
    input  logic [MASK_W-1:0]  a32_crn_mask,
    input  logic               a32_tlb_trap,
    input  logic               a32_tlbis_trap,
    output logic               res_valid,
    output logic [OUT_W-1:0]   res_outcome,
    output logic [EC_W-1:0]    res_class,
    output logic [CAUSE_W-1:0] res_cause
);
    logic       enc_hit;
    trap_ctl_t  bank_ctl;
    logic       bank_trap;
    cause_e     bank_cause;
    verdict_t   verdict;
    outcome_e   q_outcome;
    cause_e     q_cause;
    level_e     lvl;

    sysop_enc_match #(
        .CP_W(CP_W), .OP1_W(OP1_W), .CRN_W(CRN_W),
        .CRM_W(CRM_W), .OP2_W(OP2_W)
    ) u_match (
        .cp  (enc_cp),
        .op1 (enc_op1),
        .crn (enc_crn),
        .crm (enc_crm),
        .op2 (enc_op2),
        .hit (enc_hit)
    );

    // The hypervisor state selects which control bank is looked at.
    always_comb begin
        if (el2_aa32) begin
            bank_ctl.crn_hit = a32_crn_mask[enc_crn];
            bank_ctl.tlb     = a32_tlb_trap;
            bank_ctl.tlbis   = a32_tlbis_trap;
        end else begin
            bank_ctl.crn_hit = a64_crn_mask[enc_crn];
            bank_ctl.tlb     = a64_tlb_trap;
            bank_ctl.tlbis   = a64_tlbis_trap;
        end
    end

    sysop_trap_prio u_prio (
        .ctl   (bank_ctl),
        .trap  (bank_trap),
        .cause (bank_cause)
    );

    assign lvl = level_e'(cur_el);

    always_comb begin
        verdict.cause = CS_NONE;
        if (!enc_hit) begin
            verdict.outcome = OC_NOMATCH;
        end else begin
            unique case (lvl)
                LVL_0: verdict.outcome = OC_UNDEF;
                LVL_1: begin
                    if (el2_on && bank_trap) begin
                        verdict.outcome = el2_aa32 ? OC_TRAP32 : OC_TRAP64;
                        verdict.cause   = bank_cause;
                    end else begin
                        verdict.outcome = OC_EXEC;
                    end
                end
                default: verdict.outcome = OC_EXEC;
            endcase
        end
        verdict.trap = is_trap(verdict.outcome);
    end

    sysop_result_reg #(
        .EC_W(EC_W), .TRAP_EC(TRAP_EC)
    ) u_out (
        .clk       (clk),
        .rst       (rst),
        .take      (req_valid),
        .vin       (verdict),
        .q_valid   (res_valid),
        .q_outcome (q_outcome),
        .q_class   (res_class),
        .q_cause   (q_cause)
    );

    assign res_outcome = q_outcome;
    assign res_cause   = q_cause;
endmodule

// File: rtl/sysop_trap_gate_chk.sv
module sysop_trap_gate_chk (
    input logic       clk,
    input logic       rst,
    input logic       req_valid,
    input logic [3:0] enc_cp,
    input logic [2:0] enc_op1,
    input logic [3:0] enc_crn,
    input logic [3:0] enc_crm,
    input logic [2:0] enc_op2,
    input logic [1:0] cur_el,
    input logic       res_valid,
    input logic [4:0] res_outcome,
    input logic [5:0] res_class,
    input logic [1:0] res_cause
);
    logic enc_ok;
    assign enc_ok = (enc_cp == 4'hF) && (enc_op1 == 3'd0) && (enc_crn == 4'h8)
                 && (enc_crm == 4'h3) && (enc_op2 == 3'd5);

    // R2
    lat_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    // R2
    idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !res_valid);
    // R3
    one_flag_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> $onehot(res_outcome));
    // R3
    quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !res_valid |-> (res_outcome == 5'd0));
    // R11
    class_chk: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_class == (((res_outcome & 5'b01100) != 5'd0) ? 6'h03 : 6'h00)));
    // R4
    nomatch_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !enc_ok) |=> (res_outcome == 5'b00001));
    // R5
    el0_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && enc_ok && cur_el == 2'd0) |=> (res_outcome == 5'b00010));
    // R6
    upper_el_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && enc_ok && cur_el[1]) |=> (res_outcome == 5'b10000));
    // R10
    cause_chk: assert property (@(posedge clk) disable iff (rst)
        (res_cause != 2'd0) |-> ((res_outcome & 5'b01100) != 5'd0));
endmodule

bind sysop_trap_gate sysop_trap_gate_chk u_chk (
    .clk(clk), .rst(rst), .req_valid(req_valid),
    .enc_cp(enc_cp), .enc_op1(enc_op1), .enc_crn(enc_crn),
    .enc_crm(enc_crm), .enc_op2(enc_op2), .cur_el(cur_el),
    .res_valid(res_valid), .res_outcome(res_outcome),
    .res_class(res_class), .res_cause(res_cause)
);

// File: tb/test_sysop_trap_gate.sv
module test_sysop_trap_gate;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [3:0]  enc_cp = 4'hF;
    logic [2:0]  enc_op1 = 3'd0;
    logic [3:0]  enc_crn = 4'h8;
    logic [3:0]  enc_crm = 4'h3;
    logic [2:0]  enc_op2 = 3'd5;
    logic [1:0]  cur_el = 2'd0;
    logic        el2_on = 1'b0;
    logic        el2_aa32 = 1'b0;
    logic [15:0] a64_crn_mask = '0;
    logic        a64_tlb_trap = 1'b0;
    logic        a64_tlbis_trap = 1'b0;
    logic [15:0] a32_crn_mask = '0;
    logic        a32_tlb_trap = 1'b0;
    logic        a32_tlbis_trap = 1'b0;
    logic        res_valid;
    logic [4:0]  res_outcome;
    logic [5:0]  res_class;
    logic [1:0]  res_cause;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    sysop_trap_gate i_sysop_trap_gate (.*);

    localparam logic [4:0] NOM = 5'b00001, UND = 5'b00010, T64 = 5'b00100,
                           T32 = 5'b01000, EXE = 5'b10000;

    typedef struct packed {
        logic [7:0]  req;
        logic [2:0]  bad;   // 0 ok, 1 coproc, 2 opc2, 3 CRn, 4 CRm
        logic [1:0]  el;
        logic        on;
        logic        aa32;
        logic [15:0] m64;
        logic        t64;
        logic        s64;
        logic [15:0] m32;
        logic        t32;
        logic        s32;
        logic [4:0]  exp_oc;
        logic [1:0]  exp_cs;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VT [NV] = '{
        // R4 mismatches
        '{8'd4,  3'd1, 2'd1, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, NOM, 2'd0},
        '{8'd4,  3'd2, 2'd0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, NOM, 2'd0},
        '{8'd4,  3'd4, 2'd3, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, NOM, 2'd0},
        // R5
        '{8'd5,  3'd0, 2'd0, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, UND, 2'd0},
        // R6
        '{8'd6,  3'd0, 2'd2, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, EXE, 2'd0},
        '{8'd6,  3'd0, 2'd3, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, EXE, 2'd0},
        // R7
        '{8'd7,  3'd0, 2'd1, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, EXE, 2'd0},
        // R8
        '{8'd8,  3'd0, 2'd1, 1'b1, 1'b0, 16'h0100, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, T64, 2'd1},
        '{8'd8,  3'd0, 2'd1, 1'b1, 1'b0, 16'h0000, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, T64, 2'd2},
        '{8'd8,  3'd0, 2'd1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, T64, 2'd3},
        '{8'd8,  3'd0, 2'd1, 1'b1, 1'b0, 16'h0000, 1'b0, 1'b0, 16'hFFFF, 1'b1, 1'b1, EXE, 2'd0},
        // R9
        '{8'd9,  3'd0, 2'd1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h0100, 1'b0, 1'b0, T32, 2'd1},
        '{8'd9,  3'd0, 2'd1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b0, T32, 2'd2},
        '{8'd9,  3'd0, 2'd1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, T32, 2'd3},
        '{8'd9,  3'd0, 2'd1, 1'b1, 1'b1, 16'hFFFF, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, EXE, 2'd0},
        // R10 priority with several conditions set
        '{8'd10, 3'd0, 2'd1, 1'b1, 1'b0, 16'hFFFF, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, T64, 2'd1},
        '{8'd10, 3'd0, 2'd1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, T32, 2'd2},
        // R12 stray mask bits
        '{8'd12, 3'd0, 2'd1, 1'b1, 1'b0, 16'hFEFF, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, EXE, 2'd0},
        '{8'd12, 3'd0, 2'd1, 1'b1, 1'b1, 16'h0000, 1'b0, 1'b0, 16'hFEFF, 1'b0, 1'b0, EXE, 2'd0}
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        enc_cp  = (v.bad == 3'd1) ? 4'hE : 4'hF;
        enc_op1 = 3'd0;
        enc_crn = (v.bad == 3'd3) ? 4'h9 : 4'h8;
        enc_crm = (v.bad == 3'd4) ? 4'h7 : 4'h3;
        enc_op2 = (v.bad == 3'd2) ? 3'd1 : 3'd5;
        cur_el  = v.el;
        el2_on  = v.on;
        el2_aa32 = v.aa32;
        a64_crn_mask = v.m64; a64_tlb_trap = v.t64; a64_tlbis_trap = v.s64;
        a32_crn_mask = v.m32; a32_tlb_trap = v.t32; a32_tlbis_trap = v.s32;
    endtask

    function automatic logic [5:0] exp_class(input logic [4:0] oc);
        return (oc == T64 || oc == T32) ? 6'h03 : 6'h00;   // R11
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 valid", res_valid, 0);
        check("R1 outcome", res_outcome, 0);
        check("R1 class", res_class, 0);
        check("R1 cause", res_cause, 0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 idle after reset", res_valid, 0);

        for (int i = 0; i < NV; i++) begin
            apply(VT[i]);
            req_valid = 1'b1;
            @(negedge clk);
            req_valid = 1'b0;
            check($sformatf("R%0d vec%0d R2 valid", VT[i].req, i), res_valid, 1);
            check($sformatf("R%0d vec%0d outcome", VT[i].req, i), res_outcome, VT[i].exp_oc);
            check($sformatf("R%0d vec%0d R10 cause", VT[i].req, i), res_cause, VT[i].exp_cs);
            check($sformatf("R%0d vec%0d R11 class", VT[i].req, i), res_class, exp_class(VT[i].exp_oc));
            @(negedge clk);
            check($sformatf("R2 vec%0d drop", i), res_valid, 0);
            check($sformatf("R3 vec%0d quiet", i), res_outcome, 0);
        end

        // R4: CRn mismatch (9) with mask bit 9 armed must still be not-this
        apply(VT[7]);
        enc_crn = 4'h9;
        a64_crn_mask = 16'h0200;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        check("R4 crn9 outcome", res_outcome, NOM);
        check("R4 crn9 class", res_class, 0);

        // R2/R3 back-to-back strobes: trap then execute
        apply(VT[12]);
        req_valid = 1'b1;
        @(negedge clk);
        check("R9 b2b first", res_outcome, T32);
        apply(VT[6]);
        @(negedge clk);
        req_valid = 1'b0;
        check("R7 b2b second", res_outcome, EXE);
        check("R2 b2b valid", res_valid, 1);
        check("R11 b2b class", res_class, 0);

        // R1: reset arriving with a strobe clears the result
        apply(VT[8]);
        req_valid = 1'b1;
        rst = 1'b1;
        @(negedge clk);
        check("R1 reset wins valid", res_valid, 0);
        check("R1 reset wins outcome", res_outcome, 0);
        rst = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        check("R8 after reset", res_outcome, T64);
        check("R10 after reset", res_cause, 2);
        @(negedge clk);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule